// File: doc/BRIEF.md
# Three-Way Integer Ordering Comparator

This block compares two integer operands and reports how the destination operand stands relative to the source operand as three mutually exclusive status flags: below, equal or above. The result is the true mathematical ordering of the two values. It never comes from the wrapped bit pattern of a subtraction, so an operand pair whose difference would overflow the operand width still orders correctly.

Operands arrive right-aligned in 64-bit inputs. A size code selects 8, 16, 32 or 64 bits, and any bits above the selected width play no part in the result. A mode input chooses between two's-complement and unsigned interpretation. A separate strobe serves a conditional byte store: it rises when a byte-sized source is below the destination, which means the destination byte should overwrite the source location. The block is purely combinational. Status-register storage and instruction decode sit outside it.

Top module: `tri_cmp`

## Requirements
- R1: `flagNeg` is 1 exactly when the destination value is less than the source value under the selected size and mode.
- R2: `flagZero` is 1 exactly when the destination and source values are equal under the selected size.
- R3: `flagPos` is 1 exactly when the destination value is greater than the source value under the selected size and mode.
- R4: With `signedMode`=1 the operands are two's-complement and the ordering is exact even where a subtraction would overflow; for example, the most negative value compared against a positive value gives `flagNeg`=1.
- R5: With `signedMode`=0 both operands are unsigned, so a pattern with its top bit set compares above any pattern with that bit clear.
- R6: `opSize` selects the operand width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits, each taken from bit 0 upward.
- R7: Input bits at or above the selected width have no effect on any output.
- R8: Exactly one of `flagNeg`, `flagZero`, `flagPos` is 1 for every input combination.
- R9: `storeGreater` is 1 only when `opSize`=0 and the source byte is less than the destination byte under the selected mode; it is 0 for every other size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dstOpnd | input | 64 | Destination operand, right-aligned |
| srcOpnd | input | 64 | Source operand, right-aligned |
| opSize | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| signedMode | input | 1 | 1 = two's-complement, 0 = unsigned |
| flagNeg | output | 1 | Destination below source |
| flagZero | output | 1 | Destination equals source |
| flagPos | output | 1 | Destination above source |
| storeGreater | output | 1 | Byte size and source byte below destination byte |

## Verification
The hardest cases to reach are operand pairs whose sign bits differ at the selected width. In these cases a wrapped difference would give the wrong flag. They matter most at the 32- and 64-bit sizes, where random values rarely land on the extremes. The vector table places the most negative and most positive values of each width directly against each other in both modes. It also pairs equal low bits with differing upper bits to show that the upper bits are ignored. A scrambled sweep then checks every size and mode against an independent offset-binary model.

// File: rtl/tri_cmp_pkg.sv
package tri_cmp_pkg;
  localparam int BASE_W    = 8;
  localparam int NUM_SIZES = 4;
  localparam int DATA_W    = BASE_W << (NUM_SIZES - 1);
  localparam int EXT_W     = DATA_W + 1;
  localparam int SIZE_W    = $clog2(NUM_SIZES);

  typedef struct packed {
    logic [NUM_SIZES-1:0] sizeSel;   // one-hot width select
    logic                 signExt;   // fill with sign bit
    logic                 byteOp;    // narrowest width chosen
  } cmpStrobes_t;
endpackage

// File: rtl/tri_cmp_ctrl.sv
module tri_cmp_ctrl
  import tri_cmp_pkg::*;
(
  input  logic [SIZE_W-1:0] opSize,
  input  logic              signedMode,
  output cmpStrobes_t       strobes
);
  always_comb begin
    strobes.sizeSel = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (opSize == SIZE_W'(i)) strobes.sizeSel[i] = 1'b1;
    end
    strobes.signExt = signedMode;
    strobes.byteOp  = (opSize == '0);
  end
endmodule

// File: rtl/tri_cmp_dp.sv
module tri_cmp_dp
  import tri_cmp_pkg::*;
(
  input  logic [DATA_W-1:0] dstOpnd,
  input  logic [DATA_W-1:0] srcOpnd,
  input  cmpStrobes_t       strobes,
  output logic              flagNeg,
  output logic              flagZero,
  output logic              flagPos,
  output logic              storeGreater
);
  logic [EXT_W-1:0] dstExt [NUM_SIZES];
  logic [EXT_W-1:0] srcExt [NUM_SIZES];
  logic [EXT_W-1:0] dstSel;
  logic [EXT_W-1:0] srcSel;

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_width
    localparam int W = BASE_W << i;
    assign dstExt[i] = {{(EXT_W-W){strobes.signExt & dstOpnd[W-1]}}, dstOpnd[W-1:0]};
    assign srcExt[i] = {{(EXT_W-W){strobes.signExt & srcOpnd[W-1]}}, srcOpnd[W-1:0]};
  end

  always_comb begin
    dstSel = '0;
    srcSel = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (strobes.sizeSel[i]) begin
        dstSel = dstSel | dstExt[i];
        srcSel = srcSel | srcExt[i];
      end
    end
  end

  // One extra bit keeps the ordering exact: no wrap is possible.
  always_comb begin
    flagNeg      = $signed(dstSel) < $signed(srcSel);
    flagZero     = dstSel == srcSel;
    flagPos      = !flagNeg && !flagZero;
    storeGreater = strobes.byteOp && flagPos;
  end

  always_comb begin
    AST_ONE_FLAG: assert ($countones({flagNeg, flagZero, flagPos}) == 1); // R8
    AST_STORE_NEEDS_BYTE: assert (!storeGreater || (strobes.byteOp && !flagNeg)); // R9
  end
endmodule

// File: rtl/tri_cmp.sv
module tri_cmp
  import tri_cmp_pkg::*;
(
  input  logic [DATA_W-1:0] dstOpnd,
  input  logic [DATA_W-1:0] srcOpnd,
  input  logic [SIZE_W-1:0] opSize,
  input  logic              signedMode,
  output logic              flagNeg,
  output logic              flagZero,
  output logic              flagPos,
  output logic              storeGreater
);
  cmpStrobes_t strobes;

  tri_cmp_ctrl ctrl_i (
    .opSize     (opSize),
    .signedMode (signedMode),
    .strobes    (strobes)
  );

  tri_cmp_dp dp_i (
    .dstOpnd      (dstOpnd),
    .srcOpnd      (srcOpnd),
    .strobes      (strobes),
    .flagNeg      (flagNeg),
    .flagZero     (flagZero),
    .flagPos      (flagPos),
    .storeGreater (storeGreater)
  );

  logic dstTop;
  logic srcTop;
  always_comb begin
    dstTop = dstOpnd[(BASE_W << opSize) - 1];
    srcTop = srcOpnd[(BASE_W << opSize) - 1];
    AST_NO_OVERFLOW: assert (!(signedMode && dstTop && !srcTop) || flagNeg); // R4
    AST_UNSIGNED_TOP: assert (!(!signedMode && dstTop && !srcTop) || flagPos); // R5
    AST_STROBE_SIZE: assert (!storeGreater || opSize == '0); // R9
  end
endmodule

// File: tb/tri_cmp_tb_top.sv
module tri_cmp_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] dstOpnd = '0;
  logic [63:0] srcOpnd = '0;
  logic [1:0]  opSize = '0;
  logic        signedMode = 1'b0;
  logic flagNeg, flagZero, flagPos, storeGreater;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  tri_cmp dut_i (
    .dstOpnd(dstOpnd), .srcOpnd(srcOpnd), .opSize(opSize), .signedMode(signedMode),
    .flagNeg(flagNeg), .flagZero(flagZero), .flagPos(flagPos), .storeGreater(storeGreater)
  );

  typedef struct packed {
    logic [63:0] dst;
    logic [63:0] src;
    logic [1:0]  size;
    logic        sgn;
    logic [3:0]  exp;   // {neg, zero, pos, store}
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{64'h05, 64'h03, 2'd0, 1'b1, 4'b0011, 4'd9},
    '{64'h03, 64'h05, 2'd0, 1'b1, 4'b1000, 4'd1},
    '{64'h80, 64'h01, 2'd0, 1'b1, 4'b1000, 4'd4},
    '{64'h80, 64'h01, 2'd0, 1'b0, 4'b0011, 4'd5},
    '{64'h7F, 64'h80, 2'd0, 1'b1, 4'b0011, 4'd4},
    '{64'h1234, 64'h1234, 2'd1, 1'b1, 4'b0100, 4'd2},
    '{64'h8000, 64'h7FFF, 2'd1, 1'b1, 4'b1000, 4'd4},
    '{64'h8000, 64'h7FFF, 2'd1, 1'b0, 4'b0010, 4'd9},
    '{64'hFFFF_FFFF, 64'h0, 2'd2, 1'b1, 4'b1000, 4'd6},
    '{64'hFFFF_FFFF, 64'h0, 2'd2, 1'b0, 4'b0010, 4'd5},
    '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 4'b1000, 4'd4},
    '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 4'b0010, 4'd5},
    '{64'hAB00_0000_0000_0042, 64'h42, 2'd0, 1'b1, 4'b0100, 4'd7},
    '{64'hFFFF_FFFF_0000_0001, 64'h2, 2'd2, 1'b1, 4'b1000, 4'd7},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 2'd3, 1'b1, 4'b0010, 4'd3},
    '{64'h99, 64'h99, 2'd0, 1'b0, 4'b0100, 4'd2}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Offset-binary reference: flip the sign bit, then compare unsigned.
  function automatic logic [3:0] refModel(input logic [63:0] d, input logic [63:0] s,
                                          input logic [1:0] sz, input logic sg);
    int w = 8 << sz;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] a = d & m;
    logic [63:0] b = s & m;
    if (sg) begin
      a = a ^ (64'd1 << (w - 1));
      b = b ^ (64'd1 << (w - 1));
    end
    return {a < b, a == b, a > b, (sz == 2'd0) && (a > b)};
  endfunction

  task automatic applyCheck(input logic [63:0] d, input logic [63:0] s, input logic [1:0] sz,
                            input logic sg, input logic [3:0] exp, input string tag);
    logic [3:0] got;
    @(negedge clk);
    dstOpnd = d; srcOpnd = s; opSize = sz; signedMode = sg;
    #2;
    got = {flagNeg, flagZero, flagPos, storeGreater};
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: dst=%h src=%h size=%0d sgn=%0b got=%b expected=%b",
               tag, d, s, sz, sg, got, exp);
    end
  endtask

  initial begin
    #200000000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsrA = 64'h1357_9BDF_2468_ACE0;
    logic [63:0] lfsrB = 64'hF0E1_D2C3_B4A5_9687;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset state: all-zero inputs read as equal (R2, R8)
    @(negedge clk); #2;
    nChecks++;
    if ({flagNeg, flagZero, flagPos, storeGreater} !== 4'b0100) begin
      nFails++;
      $display("FAIL R2 reset: got=%b expected=0100", {flagNeg, flagZero, flagPos, storeGreater});
    end
    for (int i = 0; i < NVEC; i++)
      applyCheck(VECS[i].dst, VECS[i].src, VECS[i].size, VECS[i].sgn, VECS[i].exp,
                 reqName(VECS[i].req));
    // Directed corners
    applyCheck(64'h0, 64'h1, 2'd3, 1'b0, 4'b1000, "R1");
    applyCheck(64'h8000_0000, 64'h7FFF_FFFF, 2'd2, 1'b1, 4'b1000, "R4");
    applyCheck(64'hFF, 64'h7F, 2'd0, 1'b1, 4'b1000, "R9");
    applyCheck(64'hFF, 64'h7F, 2'd0, 1'b0, 4'b0011, "R9");
    applyCheck(64'h0000_0000_0001_0000, 64'h0000_0000_0000_FFFF, 2'd1, 1'b0, 4'b1000, "R7");
    applyCheck(64'h0000_0000_0001_0000, 64'h0000_0000_0000_FFFF, 2'd2, 1'b0, 4'b0010, "R6");
    // Scrambled sweep over every size and mode (R1, R2, R3, R8)
    for (int k = 0; k < 400; k++) begin
      logic [63:0] d;
      logic [63:0] s;
      lfsrA = {lfsrA[62:0], lfsrA[63] ^ lfsrA[62] ^ lfsrA[60] ^ lfsrA[59]};
      lfsrB = {lfsrB[62:0], lfsrB[63] ^ lfsrB[62] ^ lfsrB[60] ^ lfsrB[59]};
      d = lfsrA;
      s = (k % 5 == 0) ? lfsrA ^ {lfsrB[63:8], 8'h00} : lfsrB;
      applyCheck(d, s, 2'(k % 4), 1'((k / 4) % 2), refModel(d, s, 2'(k % 4), 1'((k / 4) % 2)),
                 "R8");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule